// File: doc/BRIEF.md
# Dual-Domain Watchdog Reload Controller

This block is an independent watchdog whose configuration lives on a fast bus clock while its counting runs on a separate slow clock. Software talks to it through a simple register port with four word registers: a key register, a divider-select register, a 12-bit reload register and a status register. The slow side holds the prescaler, the 12-bit down-counter and shadow copies of the reload and divider values. When software fails to refresh it in time, the slow side raises a one-cycle reset request.

Divider and reload writes are carried into the slow domain by a toggle handshake. While a value is in flight, its busy flag in the status register is set. Further writes to that register are dropped until the flag clears. Readback returns the slow-side shadow, so it is only meaningful once the flag has cleared. Writes to either configuration register only take effect after software has written an unlock key. Writing the start key launches counting, and only a reset can stop it again.

Top module: `wdg_ctrl`

## Requirements
- R1: After reset the reload register (byte offset 0x8) reads 0x00000FFF, the divider register (offset 0x4) reads 0 and the status register (offset 0xC) reads 0.
- R2: The key register at offset 0x0 reads as zero. Reload data sits in bits 11:0 and divider data in bits 2:0. Status bit 1 is the reload busy flag and bit 0 is the divider busy flag. Every other bit of every register reads zero.
- R3: An accepted reload write sets status bit 1 in the next bus cycle. The bit clears within 5 slow-clock cycles, and the register then reads back the written value.
- R4: An accepted divider write behaves the same way through status bit 0.
- R5: A reload or divider write issued while its own busy flag is set is dropped. Once the flag clears, the register still holds the earlier value.
- R6: Writes to the reload and divider registers are ignored unless the last key written (bits 15:0 of the key register) was 0x5555. Writing any other key, including the refresh key 0xAAAA, relocks them.
- R7: Before key 0xCCCC has been written, no reset request is ever raised.
- R8: Once started, the counter produces one-cycle reset requests spaced exactly (reload+1) × 4 × 2^min(n,6) slow cycles apart, where n is the divider field.
- R9: Writing key 0xAAAA reloads the counter and restarts the prescaler. Refreshing more often than the timeout period suppresses all reset requests.
- R10: After start, no key write stops counting. Only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-port clock |
| slow_clk | input | 1 | Independent slow counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| bus_wr | input | 1 | Write strobe, sampled on bus_clk |
| bus_addr | input | 4 | Byte offset of the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdg_rst_req | output | 1 | One-slow-cycle timeout reset request |

## Verification
A corrupted shadow register shows up at the reload or divider readback as soon as the busy flag clears, which is a few slow cycles after the write. A stuck or lost handshake toggle leaves a busy flag set past the 5-cycle bound, or lets a second write through that should have been dropped. Faults in the counter or prescaler only appear on wdg_rst_req. They show as a wrong spacing between consecutive pulses, measured in slow cycles, a pulse before start, or a pulse despite regular refreshes. That takes up to one full timeout period to become visible.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int RLD_W         = 12;
  localparam int DIV_W         = 3;
  localparam int DIV_BASE_LOG  = 2;
  localparam int DIV_SHIFT_MAX = 6;
  localparam int LEN_W         = DIV_BASE_LOG + DIV_SHIFT_MAX + 1;
  localparam int PRE_W         = LEN_W - 1;
  localparam int KEY_W         = 16;

  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  localparam logic [3:0] OFS_KEY = 4'h0;
  localparam logic [3:0] OFS_DIV = 4'h4;
  localparam logic [3:0] OFS_RLD = 4'h8;
  localparam logic [3:0] OFS_STS = 4'hC;

  localparam logic [RLD_W-1:0] RLD_RESET = '1;

  // slow cycles per prescaled tick for divider code n
  function automatic logic [LEN_W-1:0] div_len(input logic [DIV_W-1:0] n);
    logic [LEN_W-1:0] s;
    s = (LEN_W'(n) > LEN_W'(DIV_SHIFT_MAX)) ? LEN_W'(DIV_SHIFT_MAX) : LEN_W'(n);
    return LEN_W'(1) << (s + LEN_W'(DIV_BASE_LOG));
  endfunction
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/wdg_xfer.sv
module wdg_xfer #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic         s_load,
  input  logic [W-1:0] s_data,
  output logic         s_busy,
  input  logic         d_clk,
  input  logic         d_rst_n,
  output logic         d_stb,
  output logic [W-1:0] d_data
);
  logic         req_q, req_d;
  logic [W-1:0] hold_q, hold_d;
  logic         ack_s;
  logic         req_s;
  logic         ack_q;
  logic         accept;

  // source side: a load is taken only when no transfer is pending
  assign s_busy = req_q ^ ack_s;
  assign accept = s_load & ~s_busy;

  always_comb begin
    req_d  = req_q;
    hold_d = hold_q;
    if (accept) begin
      req_d  = ~req_q;
      hold_d = s_data;
    end
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      req_q  <= 1'b0;
      hold_q <= RST_VAL;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  wdg_sync #(.W(1)) u_ack_sync (.clk(s_clk), .rst_n(s_rst_n), .d(ack_q), .q(ack_s));

  // destination side
  wdg_sync #(.W(1)) u_req_sync (.clk(d_clk), .rst_n(d_rst_n), .d(req_q), .q(req_s));

  assign d_stb  = req_s ^ ack_q;
  assign d_data = hold_q;

  always_ff @(posedge d_clk or negedge d_rst_n) begin
    if (!d_rst_n) ack_q <= 1'b0;
    else          ack_q <= req_s;
  end

  assert_busy_drop_R5: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_load && s_busy) |=> $stable(hold_q));

  assert_stb_single_R3: assert property (@(posedge d_clk) disable iff (!d_rst_n)
    d_stb |=> !d_stb);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             kick,
  input  logic             rld_stb,
  input  logic [RLD_W-1:0] rld_val,
  input  logic             div_stb,
  input  logic [DIV_W-1:0] div_val,
  output logic             rst_req,
  output logic [RLD_W-1:0] rld_shadow,
  output logic [DIV_W-1:0] div_shadow
);
  logic [RLD_W-1:0] rld_q, rld_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [RLD_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             run_q, run_d;
  logic             req_q, req_d;
  logic             load_ev;
  logic             tick;

  assign load_ev = (start & ~run_q) | (run_q & kick);
  assign tick    = run_q & ({1'b0, pre_q} >= (div_len(div_q) - LEN_W'(1)));

  always_comb begin
    rld_d = rld_stb ? rld_val : rld_q;
    div_d = div_stb ? div_val : div_q;
    run_d = run_q | start;
    cnt_d = cnt_q;
    pre_d = pre_q;
    req_d = 1'b0;
    if (load_ev) begin
      cnt_d = rld_q;
      pre_d = '0;
    end else if (tick) begin
      pre_d = '0;
      if (cnt_q == '0) begin
        req_d = 1'b1;
        cnt_d = rld_q;
      end else begin
        cnt_d = cnt_q - RLD_W'(1);
      end
    end else if (run_q) begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= RLD_RESET;
      div_q <= '0;
      cnt_q <= RLD_RESET;
      pre_q <= '0;
      run_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      rld_q <= rld_d;
      div_q <= div_d;
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      run_q <= run_d;
      req_q <= req_d;
    end
  end

  assign rst_req    = req_q;
  assign rld_shadow = rld_q;
  assign div_shadow = div_q;

  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  assert_run_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !req_q);
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic        bus_clk,
  input  logic        slow_clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdg_rst_req
);
  logic             brst_n, srst_n;
  logic             unlock_q, unlock_d;
  logic             start_q, start_d;
  logic             start_s;
  logic             key_wr;
  logic [KEY_W-1:0] key;
  logic             rld_load, div_load, kick_load;
  logic             rld_busy, div_busy, kick_busy;
  logic             rld_stb, div_stb, kick_stb;
  logic [RLD_W-1:0] rld_xd, rld_shadow;
  logic [DIV_W-1:0] div_xd, div_shadow;
  logic             kick_xd;

  // per-domain reset release
  wdg_sync #(.W(1)) u_brst (.clk(bus_clk),  .rst_n(rst_n), .d(1'b1), .q(brst_n));
  wdg_sync #(.W(1)) u_srst (.clk(slow_clk), .rst_n(rst_n), .d(1'b1), .q(srst_n));

  assign key       = bus_wdata[KEY_W-1:0];
  assign key_wr    = bus_wr && (bus_addr == OFS_KEY);
  assign rld_load  = bus_wr && (bus_addr == OFS_RLD) && unlock_q;
  assign div_load  = bus_wr && (bus_addr == OFS_DIV) && unlock_q;
  assign kick_load = key_wr && (key == KEY_REFRESH);

  always_comb begin
    unlock_d = unlock_q;
    if (key_wr) unlock_d = (key == KEY_UNLOCK);
    start_d = start_q | (key_wr && (key == KEY_START));
  end

  always_ff @(posedge bus_clk or negedge brst_n) begin
    if (!brst_n) begin
      unlock_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      unlock_q <= unlock_d;
      start_q  <= start_d;
    end
  end

  wdg_xfer #(.W(RLD_W), .RST_VAL(RLD_RESET)) u_rld_x (
    .s_clk(bus_clk), .s_rst_n(brst_n), .s_load(rld_load),
    .s_data(bus_wdata[RLD_W-1:0]), .s_busy(rld_busy),
    .d_clk(slow_clk), .d_rst_n(srst_n), .d_stb(rld_stb), .d_data(rld_xd));

  wdg_xfer #(.W(DIV_W), .RST_VAL('0)) u_div_x (
    .s_clk(bus_clk), .s_rst_n(brst_n), .s_load(div_load),
    .s_data(bus_wdata[DIV_W-1:0]), .s_busy(div_busy),
    .d_clk(slow_clk), .d_rst_n(srst_n), .d_stb(div_stb), .d_data(div_xd));

  // a refresh arriving while one is in flight merges with it
  wdg_xfer #(.W(1), .RST_VAL(1'b0)) u_kick_x (
    .s_clk(bus_clk), .s_rst_n(brst_n), .s_load(kick_load),
    .s_data(1'b1), .s_busy(kick_busy),
    .d_clk(slow_clk), .d_rst_n(srst_n), .d_stb(kick_stb), .d_data(kick_xd));

  wdg_sync #(.W(1)) u_start_sync (.clk(slow_clk), .rst_n(srst_n), .d(start_q), .q(start_s));

  wdg_core u_core (
    .clk(slow_clk), .rst_n(srst_n), .start(start_s), .kick(kick_stb & kick_xd),
    .rld_stb(rld_stb), .rld_val(rld_xd), .div_stb(div_stb), .div_val(div_xd),
    .rst_req(wdg_rst_req), .rld_shadow(rld_shadow), .div_shadow(div_shadow));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DIV: bus_rdata[DIV_W-1:0] = div_shadow;
      OFS_RLD: bus_rdata[RLD_W-1:0] = rld_shadow;
      OFS_STS: bus_rdata[1:0]       = {rld_busy, div_busy};
      default: bus_rdata = '0;
    endcase
  end

  assert_locked_rld_R6: assert property (@(posedge bus_clk) disable iff (!brst_n)
    (bus_wr && bus_addr == OFS_RLD && !unlock_q && !rld_busy) |=> !rld_busy);

  assert_locked_div_R6: assert property (@(posedge bus_clk) disable iff (!brst_n)
    (bus_wr && bus_addr == OFS_DIV && !unlock_q && !div_busy) |=> !div_busy);

  assert_start_sticky_R10: assert property (@(posedge bus_clk) disable iff (!brst_n)
    start_q |=> start_q);

  assert_kick_busy_seen_R9: assert property (@(posedge bus_clk) disable iff (!brst_n)
    (kick_load && !kick_busy) |=> kick_busy);
endmodule

// File: tb/sim_wdg_ctrl.sv
module sim_wdg_ctrl;
  logic        bus_clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdg_rst_req;

  int n_chk = 0;
  int n_err = 0;
  int slow_cnt = 0;
  int pulse_cnt = 0;
  int last_t = 0;
  int last_gap = 0;

  wdg_ctrl u0 (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdg_rst_req(wdg_rst_req));

  always #4 bus_clk = ~bus_clk;
  always begin
    #18 slow_clk = 1'b1;
    #19 slow_clk = 1'b0;
  end

  always @(negedge slow_clk) begin
    slow_cnt <= slow_cnt + 1;
    if (wdg_rst_req) begin
      pulse_cnt <= pulse_cnt + 1;
      last_gap  <= slow_cnt - last_t;
      last_t    <= slow_cnt;
    end
  end

  function automatic int exp_period(input int rl, input int n);
    int s;
    s = (n > 6) ? 6 : n;
    return (rl + 1) * (4 << s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output int slow_took);
    logic [31:0] s;
    int t0;
    t0 = slow_cnt;
    for (int i = 0; i < 400; i++) begin
      rd(4'hC, s);
      if (s[1:0] == 2'b00) break;
    end
    slow_took = slow_cnt - t0;
  endtask

  task automatic wait_pulses(input int n);
    int target;
    target = pulse_cnt + n;
    for (int i = 0; i < 4000 && pulse_cnt < target; i++) @(negedge slow_clk);
    @(negedge bus_clk);
  endtask

  task automatic cfg(input int rl, input int dv);
    int t;
    wr(4'h0, 32'h5555);
    wr(4'h8, rl);
    wait_idle(t);
    wr(4'h4, dv);
    wait_idle(t);
  endtask

  initial begin
    repeat (190000) @(posedge bus_clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t, p0;
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0;
    repeat (5) @(negedge bus_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge slow_clk);

    // R1 / R2 reset values and reserved bits
    rd(4'h8, v); chk("R1 reload reset", v, 32'h0000_0FFF);
    rd(4'h4, v); chk("R1 divider reset", v, 32'h0);
    rd(4'hC, v); chk("R1 status reset", v, 32'h0);
    rd(4'h0, v); chk("R2 key reads zero", v, 32'h0);

    // R6 locked write ignored
    wr(4'h8, 32'h0000_0123);
    rd(4'hC, v); chk("R6 locked no busy", v, 32'h0);
    repeat (10) @(negedge slow_clk);
    rd(4'h8, v); chk("R6 locked reload unchanged", v, 32'h0000_0FFF);

    // R3 busy set, bounded, readback; R2 upper bits
    wr(4'h0, 32'h5555);
    wr(4'h8, 32'hFFFF_F005);
    rd(4'hC, v); chk("R3 reload busy set", v, 32'h2);
    wait_idle(t);
    chk("R3 busy bound", (t <= 5), 32'h1);
    rd(4'h8, v); chk("R3 R2 reload readback", v, 32'h0000_0005);

    // R4 divider
    wr(4'h4, 32'hFFFF_FFF3);
    rd(4'hC, v); chk("R4 divider busy set", v, 32'h1);
    wait_idle(t);
    chk("R4 busy bound", (t <= 5), 32'h1);
    rd(4'h4, v); chk("R4 R2 divider readback", v, 32'h3);

    // R5 second write while busy dropped
    wr(4'h8, 32'h010);
    wr(4'h8, 32'h020);
    wait_idle(t);
    rd(4'h8, v); chk("R5 reload busy write dropped", v, 32'h010);
    wr(4'h4, 32'h5);
    wr(4'h4, 32'h6);
    wait_idle(t);
    rd(4'h4, v); chk("R5 divider busy write dropped", v, 32'h5);

    // R6 relock by refresh key and by arbitrary key
    wr(4'h0, 32'hAAAA);
    wr(4'h8, 32'h030);
    repeat (8) @(negedge slow_clk);
    rd(4'h8, v); chk("R6 relock by refresh", v, 32'h010);
    wr(4'h0, 32'h5555);
    wr(4'h0, 32'h1234);
    wr(4'h4, 32'h2);
    repeat (8) @(negedge slow_clk);
    rd(4'h4, v); chk("R6 relock by other key", v, 32'h5);

    // R3 R4 random configurations
    for (int i = 0; i < 6; i++) begin
      logic [11:0] rr;
      logic [2:0]  dd;
      rr = 12'($urandom);
      dd = 3'($urandom);
      cfg(int'(rr), int'(dd));
      rd(4'h8, v); chk("R3 random reload", v, {20'h0, rr});
      rd(4'h4, v); chk("R4 random divider", v, {29'h0, dd});
    end

    // R7 no request before start
    cfg(3, 0);
    repeat (100) @(negedge slow_clk);
    chk("R7 no pulse before start", pulse_cnt, 32'd0);

    // R8 periods
    wr(4'h0, 32'hCCCC);
    wait_pulses(3);
    chk("R8 period rl3 n0", last_gap, exp_period(3, 0));
    cfg(2, 1);
    wait_pulses(2);
    chk("R8 period rl2 n1", last_gap, exp_period(2, 1));
    cfg(0, 7);
    wait_pulses(2);
    chk("R8 period rl0 n7", last_gap, exp_period(0, 7));
    begin
      int r;
      r = int'($urandom % 16);
      cfg(r, 2);
      wait_pulses(2);
      chk("R8 period random", last_gap, exp_period(r, 2));
    end

    // R9 regular refresh suppresses requests
    cfg(20, 0);
    wait_pulses(2);
    wr(4'h0, 32'hAAAA);
    p0 = pulse_cnt;
    for (int i = 0; i < 20; i++) begin
      repeat (30) @(negedge slow_clk);
      wr(4'h0, 32'hAAAA);
    end
    chk("R9 refresh suppresses", pulse_cnt, p0);

    // R10 keys cannot stop counting
    wr(4'h0, 32'h0000);
    wr(4'h0, 32'h5555);
    wr(4'h0, 32'hFFFF);
    p0 = pulse_cnt;
    wait_pulses(2);
    chk("R10 still running", (pulse_cnt >= p0 + 2), 32'h1);
    chk("R10 period kept", last_gap, exp_period(20, 0));

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule